// File: doc/BRIEF.md
# GPIO Group Direction and Output Register Bank

This block holds the pad-control state for several 32-pin GPIO groups behind a simple synchronous register bus. Each group owns a direction vector (1 = pin driven as an output, 0 = pin left as an input) and an output-value vector. Both vectors can be written whole. They can also be changed through aliases that set, clear or invert only the bits written as 1, so firmware never needs a read-modify-write to touch a single pin.

Groups sit at a fixed stride of 0x80 bytes, with group 0 at the bank base. Inside a group, address bit 4 selects the vector: 0 selects direction and 1 selects output value. Address bits [3:2] select the operation: 0 = whole write, 1 = clear, 2 = set, 3 = toggle. This gives direction at 0x00/0x04/0x08/0x0C and output at 0x10/0x14/0x18/0x1C. Address bits [1:0] are ignored.

The direction and output vectors of every group leave the block as registered pad-enable and pad-value buses. Pin `p` of group `g` is bit `g*32+p`. The pad value always tracks the output register, whether the pin is driven or not. Firmware can therefore load the level first and then enable the driver, with no stale level appearing on the pin.

Top module: `gpio_bank_regs`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, every direction and output bit of every group is 0, so pad_oe and pad_out are all zero.
- R2: A write to group offset 0x00 replaces the whole direction vector with bus_wdata. A write to 0x10 replaces the whole output vector.
- R3: A write to offset 0x08 sets the direction bits where bus_wdata is 1 and leaves the other direction bits unchanged. It does not change the output vector.
- R4: A write to offset 0x04 clears the direction bits where bus_wdata is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts the direction bits where bus_wdata is 1 and leaves the other bits unchanged.
- R6: Writes to 0x18, 0x14 and 0x1C set, clear and invert (in that order of offsets) the output bits where bus_wdata is 1. Zero bits and the direction vector are unaffected.
- R7: bus_rdata is combinational from the current state. An address with bit 4 = 0 in offsets 0x00–0x1C returns that group's direction vector, and one with bit 4 = 1 returns its output vector, whichever alias is addressed. Unmapped offsets (0x20–0x7C) and absent groups read as 0.
- R8: Group g answers at base g*0x80. A write to one group never changes another group's vectors.
- R9: Writes to offsets 0x20–0x7C, or to group indices at or above NUM_GROUPS, change nothing.
- R10: A write presented with bus_we high takes effect on that clock edge, and the pads show it from then on. A read in the same cycle as a write returns the value from before the write. With bus_we low, nothing changes.
- R11: pad_out follows the output vector even for pins whose direction bit is 0. When a direction bit is set, the pin drives the level that was already loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: group in bits [ADDR_W-1:7], register offset in [6:0] |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_oe | output | NUM_GROUPS*32 | Per-pin driver enable (1 = output) |
| pad_out | output | NUM_GROUPS*32 | Per-pin output level |

## Verification
Two things can land in the same cycle: a read returns state through the combinational path while a write to the same address updates that state at the clock edge. The bench presents each write, samples bus_rdata before the edge and compares it with the pre-write model value. It then compares the pads after the edge with the post-write model. Random streams hit the same group and alias back to back, so the read-before-write order is judged on every write, including when aliases of the same vector follow each other.

// File: rtl/gpio_bank_pkg.sv
// gpio_bank_pkg: shared constants and types for the GPIO register bank.
// Assumes a 32-bit bus and 32 pins per group.
package gpio_bank_pkg;

    localparam int PINS = 32;

    // Register select: bit 2 picks the vector, bits 1:0 pick the operation.
    typedef enum logic [2:0] {
        SEL_DIR_WR  = 3'd0,
        SEL_DIR_CLR = 3'd1,
        SEL_DIR_SET = 3'd2,
        SEL_DIR_TGL = 3'd3,
        SEL_OUT_WR  = 3'd4,
        SEL_OUT_CLR = 3'd5,
        SEL_OUT_SET = 3'd6,
        SEL_OUT_TGL = 3'd7
    } reg_sel_e;

    // Bit-update operation shared by both vectors.
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } bit_op_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// gpio_addr_decode: splits a bank byte address into a one-hot group hit and
// a register select. Assumes a power-of-two group stride of 2**OFF_W bytes.
// Only offsets 0x00-0x1C are mapped, and byte lanes [1:0] are ignored.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int ADDR_W     = 10,
    parameter int OFF_W      = 7
) (
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    output logic [NUM_GROUPS-1:0] grp_hit,
    output logic [NUM_GROUPS-1:0] grp_wr,
    output reg_sel_e              sel
);
    localparam int GRP_W = ADDR_W - OFF_W;

    logic [GRP_W-1:0] grp_idx;
    logic             mapped;
    logic             unused_lanes;

    // Field extraction from the byte address.
    always_comb begin
        grp_idx      = bus_addr[ADDR_W-1:OFF_W];
        mapped       = (bus_addr[OFF_W-1:5] == '0);
        sel          = reg_sel_e'(bus_addr[4:2]);
        unused_lanes = ^bus_addr[1:0];
    end

    // One comparator per implemented group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
        always_comb begin
            grp_hit[g] = mapped && (grp_idx == GRP_W'(g));
            grp_wr[g]  = grp_hit[g] && bus_we;
        end
    end

endmodule

// File: rtl/gpio_atomic_reg.sv
// gpio_atomic_reg: one WIDTH-bit register with whole-write, clear-mask,
// set-mask and toggle-mask updates. Assumes the caller gives one op per cycle.
module gpio_atomic_reg
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  bit_op_e          op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // Next value under the selected bit operation.
    always_comb begin
        unique case (op)
            OP_WRITE:  nxt = wdata;
            OP_CLEAR:  nxt = q & ~wdata;
            OP_SET:    nxt = q | wdata;
            OP_TOGGLE: nxt = q ^ wdata;
            default:   nxt = q;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/gpio_group_regs.sv
// gpio_group_regs: direction and output vectors for one pin group.
// Assumes wr_en is already qualified by group hit and write strobe.
module gpio_group_regs
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q
);
    logic    wr_dir;
    logic    wr_out;
    bit_op_e op;

    // Route the write to one vector and extract the operation.
    always_comb begin
        wr_dir = wr_en && !sel[2];
        wr_out = wr_en &&  sel[2];
        op     = bit_op_e'(sel[1:0]);
    end

    gpio_atomic_reg #(.WIDTH(PINS)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_dir),
        .op    (op),
        .wdata (wdata),
        .q     (dir_q)
    );

    gpio_atomic_reg #(.WIDTH(PINS)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_out),
        .op    (op),
        .wdata (wdata),
        .q     (out_q)
    );

endmodule

// File: rtl/gpio_read_mux.sv
// gpio_read_mux: AND-OR read path over all groups. Assumes grp_hit is
// one-hot or zero, and returns 0 when no group is hit.
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 3
) (
    input  logic [NUM_GROUPS-1:0]      grp_hit,
    input  logic                       pick_out,
    input  logic [NUM_GROUPS*PINS-1:0] dir_all,
    input  logic [NUM_GROUPS*PINS-1:0] out_all,
    output logic [PINS-1:0]            rdata
);
    // OR together the selected vector of the hit group.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_hit[g]) begin
                rdata = rdata | (pick_out ? out_all[g*PINS +: PINS]
                                          : dir_all[g*PINS +: PINS]);
            end
        end
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// gpio_bank_regs: top of the GPIO bank. Each group holds direction and
// output registers with set, clear and toggle aliases. Group g sits at
// g * 2**OFF_W. Pads are driven straight from the registers.
// Assumes one bus access per cycle and no wait states.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int ADDR_W     = 10,
    parameter int OFF_W      = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_GROUPS*PINS-1:0] pad_oe,
    output logic [NUM_GROUPS*PINS-1:0] pad_out
);
    logic [NUM_GROUPS-1:0] grp_hit;
    logic [NUM_GROUPS-1:0] grp_wr;
    reg_sel_e              sel;
    logic                  pick_out;

    gpio_addr_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .grp_hit  (grp_hit),
        .grp_wr   (grp_wr),
        .sel      (sel)
    );

    // One register pair per group, placed on its slice of the pad buses.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpio_group_regs u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (grp_wr[g]),
            .sel   (sel),
            .wdata (bus_wdata),
            .dir_q (pad_oe[g*PINS +: PINS]),
            .out_q (pad_out[g*PINS +: PINS])
        );
    end

    // Vector choice for the read path.
    always_comb pick_out = sel[2];

    gpio_read_mux #(.NUM_GROUPS(NUM_GROUPS)) u_rd (
        .grp_hit  (grp_hit),
        .pick_out (pick_out),
        .dir_all  (pad_oe),
        .out_all  (pad_out),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/gpio_bank_regs_checker.sv
// gpio_bank_regs_checker: protocol properties of the bank, seen at its ports.
// Per-bit checks look at group 0. Bound into every gpio_bank_regs instance.
module gpio_bank_regs_checker #(
    parameter int NUM_GROUPS = 3,
    parameter int ADDR_W     = 10,
    parameter int OFF_W      = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_we,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic [NUM_GROUPS*32-1:0] pad_oe,
    input logic [NUM_GROUPS*32-1:0] pad_out
);
    logic g0;
    logic mapped;

    // Port-level address qualifiers.
    always_comb begin
        g0     = (bus_addr[ADDR_W-1:OFF_W] == '0);
        mapped = (bus_addr[OFF_W-1:5] == '0);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe) && $stable(pad_out)); // R10

    AST_DIRSET_G0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && g0 && mapped && (bus_addr[4:2] == 3'd2)
        |=> pad_oe[31:0] == ($past(pad_oe[31:0]) | $past(bus_wdata))); // R3

    AST_DIRCLR_G0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && g0 && mapped && (bus_addr[4:2] == 3'd1)
        |=> pad_oe[31:0] == ($past(pad_oe[31:0]) & ~$past(bus_wdata))); // R4

    AST_OUT_ALIAS_KEEPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr[4] |=> $stable(pad_oe)); // R6

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !mapped |=> $stable(pad_oe) && $stable(pad_out)); // R9

    AST_READ_DIR_G0: assert property (@(posedge clk) disable iff (!rst_n)
        g0 && mapped && !bus_addr[4] |-> bus_rdata == pad_oe[31:0]); // R7

endmodule

bind gpio_bank_regs gpio_bank_regs_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;
    localparam int NG = 3;
    localparam int AW = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NG*32-1:0]  pad_oe;
    logic [NG*32-1:0]  pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_dir [NG];
    logic [31:0] m_out [NG];

    always #2.5 clk = ~clk;

    gpio_bank_regs #(.NUM_GROUPS(NG), .ADDR_W(AW), .OFF_W(7)) u_gpio_bank_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int g = int'(a[AW-1:7]);
        if (g >= NG || a[6:5] != 2'b00) return 32'h0;
        return a[4] ? m_out[g] : m_dir[g];
    endfunction

    function automatic logic [31:0] apply_op(input logic [1:0] op,
                                              input logic [31:0] cur,
                                              input logic [31:0] d);
        case (op)
            2'd0: return d;
            2'd1: return cur & ~d;
            2'd2: return cur | d;
            default: return cur ^ d;
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int g = int'(a[AW-1:7]);
        if (g >= NG || a[6:5] != 2'b00) return;
        if (a[4]) m_out[g] = apply_op(a[3:2], m_out[g], d);
        else      m_dir[g] = apply_op(a[3:2], m_dir[g], d);
    endtask

    function automatic logic [NG*32-1:0] exp_oe();
        logic [NG*32-1:0] v;
        for (int g = 0; g < NG; g++) v[g*32 +: 32] = m_dir[g];
        return v;
    endfunction

    function automatic logic [NG*32-1:0] exp_pad();
        logic [NG*32-1:0] v;
        for (int g = 0; g < NG; g++) v[g*32 +: 32] = m_out[g];
        return v;
    endfunction

    task automatic check(input string req, input logic [NG*32-1:0] act,
                         input logic [NG*32-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check read-before-write, then pads.
    task automatic cycle(input string req, input logic [AW-1:0] a,
                         input bit we, input logic [31:0] d);
        bus_addr = a; bus_we = we; bus_wdata = d;
        #1;
        check("R7/R10 read", {{(NG-1)*32{1'b0}}, bus_rdata},
              {{(NG-1)*32{1'b0}}, model_read(a)});
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
        check(req, pad_oe, exp_oe());
        check(req, pad_out, exp_pad());
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int g = 0; g < NG; g++) begin m_dir[g] = '0; m_out[g] = '0; end
        repeat (4) @(negedge clk);
        check("R1 reset oe", pad_oe, '0);
        check("R1 reset out", pad_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", pad_oe | pad_out, '0);

        // R11: load the level first, drivers still off
        cycle("R2 R11 out load", 10'h010, 1, 32'hA5A5_0F0F);
        check("R11 undriven", pad_oe, '0);
        cycle("R3 R11 dirset", 10'h008, 1, 32'h0000_FFFF);
        check("R11 level kept", {{(NG-1)*32{1'b0}}, pad_out[31:0]},
              {{(NG-1)*32{1'b0}}, 32'hA5A5_0F0F});
        cycle("R4 dirclr", 10'h004, 1, 32'h0000_00F0);
        cycle("R5 dirtgl", 10'h00C, 1, 32'hFF00_00FF);
        cycle("R6 outset", 10'h018, 1, 32'h0000_F000);
        cycle("R6 outclr", 10'h014, 1, 32'hA000_0001);
        cycle("R6 outtgl", 10'h01C, 1, 32'hFFFF_0000);
        cycle("R2 dir write", 10'h000, 1, 32'h1234_5678);
        cycle("R8 group1", 10'h090, 1, 32'hDEAD_BEEF);
        cycle("R8 group2", 10'h108, 1, 32'h8000_0001);
        cycle("R9 unmapped off", 10'h020, 1, 32'hFFFF_FFFF);
        cycle("R9 unmapped off", 10'h07C, 1, 32'hFFFF_FFFF);
        cycle("R9 absent group", 10'h180, 1, 32'hFFFF_FFFF);
        cycle("R9 absent group", 10'h398, 1, 32'hFFFF_FFFF);
        cycle("R7 alias read", 10'h00C, 0, 32'h0);
        cycle("R7 alias read", 10'h11C, 0, 32'h0);
        cycle("R10 idle", 10'h010, 0, 32'hFFFF_FFFF);
        cycle("R10 back-to-back", 10'h01C, 1, 32'h0F0F_0F0F);
        cycle("R10 back-to-back", 10'h01C, 1, 32'h00FF_00FF);

        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [6:0] off;
            a = '0;
            off = ($urandom_range(0, 9) != 0) ? 7'($urandom_range(0, 31))
                                               : 7'($urandom_range(0, 127));
            a[AW-1:7] = 3'($urandom_range(0, 3));
            a[6:0] = off;
            cycle("R2-R6 random", a, $urandom_range(0, 4) != 0, $urandom);
        end

        // R1 reset clears everything again
        bus_addr = '0; rst_n = 1'b0;
        @(negedge clk);
        for (int g = 0; g < NG; g++) begin m_dir[g] = '0; m_out[g] = '0; end
        check("R1 re-reset", pad_oe | pad_out, '0);
        done = 1;
        finish_run();
    end
endmodule